// File: doc/BRIEF.md
# Energy-Harvest Phase Sequencer

This block is the digital sequencer of a switched-capacitor front end that harvests energy from a piezoelectric source. It receives raw comparator flags: a wake event, a peak flag, a level comparison against a selectable reference, a high and a low threshold near the maximum safe input, and a reverse-current flag. From these it drives the four power-switch enables, a 3-bit conversion-ratio code, a 3-bit reference-select code and the enables of the three trackers.

A harvest starts with a wake event. While the input rises, a level counter climbs one reference step each time the input passes the reference. If the input reaches the maximum safe level, short partial-extraction bursts at the deepest ratio pull it back by about one volt. These bursts can repeat until the peak arrives. After the peak, full extraction begins at the recorded ratio, with the reference one step lower. The ratio then falls one step each time the input drops under the reference. Once the input falls below the lowest level, the converter path opens, one dead cycle passes, and a direct path charges the battery until reverse current is seen. The block then clears itself for the next wake event.

Top module: `harvest_seq`

## Requirements
- R1: After reset and in idle, every switch enable and tracker enable is 0, and ratio_code and ref_sel are 0. In idle, every flag except wake (including peak, high threshold and level) is ignored.
- R2: Each flag passes through SYNC_STAGES flops. The controller acts on a flag only when the synchronised value is high in two consecutive cycles, so a flag that is high for one clock is ignored. With the default of 2 stages, a flag that goes high before clock edge k changes the outputs just after edge k+3.
- R3: In rising-level tracking, only lvl_trk_en and hi_trk_en are 1, ratio_code is 0 and ref_sel equals the level count. A qualified level-above flag raises the count by one. The count saturates at 7. After each step the level flag is ignored for SETTLE_CYC cycles.
- R4: A qualified high-threshold flag in tracking (and no peak) starts partial extraction. s1_en and s2_en go to 1, ratio_code goes to 7 (the 1/8 ratio), only lo_trk_en is on, and the count is set to 7.
- R5: In partial extraction, a qualified low-threshold flag returns the block to tracking. The high tracker is re-armed there, so further partial bursts can follow before the peak.
- R6: A qualified peak flag in tracking wins over the high-threshold flag. It starts full extraction with s1_en and s2_en at 1, ratio_code equal to the recorded count, ref_sel one below it (0 when the count is 0), and only lvl_trk_en on.
- R7: In full extraction, once the settle window has passed, a qualified low level flag (input below the reference) lowers the count, and so both ratio_code and ref_sel, by exactly one.
- R8: In full extraction, a below-reference event at count 0 or 1 opens s1_en and s2_en. All switches stay open for exactly one cycle, and then sx_en and sy_en close. The two pairs are never closed together.
- R9: During direct transfer, a qualified reverse-current flag opens sx_en and sy_en. One cycle later the block is back in idle with the count and ref_sel at 0, ready for the next wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | Raw wake-event flag |
| peak_i | input | 1 | Raw peak-detected flag |
| lvl_above_i | input | 1 | Raw level flag: 1 when the divided input exceeds the selected reference |
| hi_thr_i | input | 1 | Raw flag: input at the maximum safe level |
| lo_thr_i | input | 1 | Raw flag: input back at the partial-burst lower threshold |
| rev_i | input | 1 | Raw reverse-current flag |
| s1_en | output | 1 | Input-side converter switch enable |
| s2_en | output | 1 | Output-side converter switch enable |
| sx_en | output | 1 | Direct-path input switch enable |
| sy_en | output | 1 | Direct-path output switch enable |
| ratio_code | output | LVL_W | Conversion-ratio code (0 = ratio 1, 7 = ratio 1/8) |
| ref_sel | output | LVL_W | Reference-ladder select (0 = lowest step, each code +0.5 V) |
| lvl_trk_en | output | 1 | Level tracker enable |
| hi_trk_en | output | 1 | High-threshold tracker enable |
| lo_trk_en | output | 1 | Low-threshold tracker enable |

## Verification
The bench uses the default parameters: a 3-bit level count, two synchroniser stages and a 4-cycle settle window. With these values the full ladder from ratio 1 to 1/8 and the saturation at code 7 fit into ramps of a few hundred cycles. A behavioural source model raises and discharges an integer input voltage. It derives every flag from that voltage and from the block's own ref_sel, which closes the loop. A strong ramp forces repeated partial bursts. A weak ramp and a very weak ramp reach full extraction at mid-ladder and at count 0. Single-cycle glitches and stray flags in idle cover the qualification and ignore rules.

// File: rtl/harvest_pkg.sv
package harvest_pkg;

    localparam int NFLAG  = 6;
    localparam int F_WAKE = 0;
    localparam int F_PEAK = 1;
    localparam int F_LVL  = 2;
    localparam int F_HI   = 3;
    localparam int F_LO   = 4;
    localparam int F_REV  = 5;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_TRACK   = 3'd1,
        PH_PARTIAL = 3'd2,
        PH_FULL    = 3'd3,
        PH_GAP     = 3'd4,
        PH_DIRECT  = 3'd5,
        PH_CLOSE   = 3'd6
    } phase_e;

    typedef struct packed {
        logic up;
        logic down;
        logic to_top;
        logic to_zero;
        logic settle;
    } lvl_cmd_t;

    typedef struct packed {
        logic conv_on;
        logic direct_on;
        logic lvl_en;
        logic hi_en;
        logic lo_en;
    } drive_t;

    function automatic drive_t phase_drive(phase_e p);
        drive_t d;
        d = '0;
        unique case (p)
            PH_TRACK:   begin d.lvl_en = 1'b1; d.hi_en = 1'b1; end
            PH_PARTIAL: begin d.conv_on = 1'b1; d.lo_en = 1'b1; end
            PH_FULL:    begin d.conv_on = 1'b1; d.lvl_en = 1'b1; end
            PH_DIRECT:  d.direct_on = 1'b1;
            default:    d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hs_flag_sync.sv
module hs_flag_sync #(
    parameter int N      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] q_hi,
    output logic [N-1:0] q_lo
);
    logic [STAGES-1:0][N-1:0] chain;
    logic [N-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= raw;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prev <= chain[STAGES-1];
        end
    end

    assign q_hi = chain[STAGES-1] & prev;
    assign q_lo = ~chain[STAGES-1] & ~prev;
endmodule

// File: rtl/hs_level_ctr.sv
module hs_level_ctr
    import harvest_pkg::*;
#(
    parameter int W      = 3,
    parameter int SETTLE = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  lvl_cmd_t     cmd,
    output logic [W-1:0] cnt,
    output logic         settled
);
    localparam int HW = $clog2(SETTLE + 1);
    localparam logic [W-1:0] TOP = '1;

    logic [HW-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hold <= '0;
        end else begin
            if (cmd.to_zero)                 cnt <= '0;
            else if (cmd.to_top)             cnt <= TOP;
            else if (cmd.up && cnt != TOP)   cnt <= cnt + 1'b1;
            else if (cmd.down && cnt != '0)  cnt <= cnt - 1'b1;

            if (cmd.settle)                  hold <= HW'(SETTLE);
            else if (hold != '0)             hold <= hold - 1'b1;
        end
    end

    assign settled = (hold == '0);
endmodule

// File: rtl/hs_phase_fsm.sv
module hs_phase_fsm
    import harvest_pkg::*;
#(
    parameter int W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] q_hi,
    input  logic [NFLAG-1:0] q_lo,
    input  logic [W-1:0]     cnt,
    input  logic             settled,
    output phase_e           phase,
    output lvl_cmd_t         cmd
);
    phase_e nxt;

    always_comb begin
        nxt = phase;
        cmd = '0;
        unique case (phase)
            PH_IDLE: if (q_hi[F_WAKE]) begin
                nxt = PH_TRACK;
                cmd.settle = 1'b1;
            end
            PH_TRACK: begin
                if (q_hi[F_PEAK]) begin
                    nxt = PH_FULL;
                    cmd.settle = 1'b1;
                end else if (q_hi[F_HI]) begin
                    nxt = PH_PARTIAL;
                    cmd.to_top = 1'b1;
                end else if (settled && q_hi[F_LVL]) begin
                    cmd.up = 1'b1;
                    cmd.settle = 1'b1;
                end
            end
            PH_PARTIAL: if (q_hi[F_LO]) begin
                nxt = PH_TRACK;
                cmd.settle = 1'b1;
            end
            PH_FULL: if (settled && q_lo[F_LVL]) begin
                if (cnt <= W'(1)) begin
                    nxt = PH_GAP;
                    cmd.to_zero = 1'b1;
                end else begin
                    cmd.down = 1'b1;
                    cmd.settle = 1'b1;
                end
            end
            PH_GAP:    nxt = PH_DIRECT;
            PH_DIRECT: if (q_hi[F_REV]) nxt = PH_CLOSE;
            PH_CLOSE: begin
                nxt = PH_IDLE;
                cmd.to_zero = 1'b1;
            end
            default:   nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/harvest_seq.sv
module harvest_seq
    import harvest_pkg::*;
#(
    parameter int LVL_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_i,
    input  logic             peak_i,
    input  logic             lvl_above_i,
    input  logic             hi_thr_i,
    input  logic             lo_thr_i,
    input  logic             rev_i,
    output logic             s1_en,
    output logic             s2_en,
    output logic             sx_en,
    output logic             sy_en,
    output logic [LVL_W-1:0] ratio_code,
    output logic [LVL_W-1:0] ref_sel,
    output logic             lvl_trk_en,
    output logic             hi_trk_en,
    output logic             lo_trk_en
);
    localparam logic [LVL_W-1:0] DEEPEST = '1;

    logic [NFLAG-1:0] raw, q_hi, q_lo;
    logic [LVL_W-1:0] cnt;
    logic             settled;
    phase_e           phase;
    lvl_cmd_t         cmd;
    drive_t           drv;

    always_comb begin
        raw         = '0;
        raw[F_WAKE] = wake_i;
        raw[F_PEAK] = peak_i;
        raw[F_LVL]  = lvl_above_i;
        raw[F_HI]   = hi_thr_i;
        raw[F_LO]   = lo_thr_i;
        raw[F_REV]  = rev_i;
    end

    hs_flag_sync #(.N(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw), .q_hi(q_hi), .q_lo(q_lo)
    );

    hs_level_ctr #(.W(LVL_W), .SETTLE(SETTLE_CYC)) u_ctr (
        .clk(clk), .rst(rst), .cmd(cmd), .cnt(cnt), .settled(settled)
    );

    hs_phase_fsm #(.W(LVL_W)) u_fsm (
        .clk(clk), .rst(rst), .q_hi(q_hi), .q_lo(q_lo), .cnt(cnt),
        .settled(settled), .phase(phase), .cmd(cmd)
    );

    assign drv        = phase_drive(phase);
    assign s1_en      = drv.conv_on;
    assign s2_en      = drv.conv_on;
    assign sx_en      = drv.direct_on;
    assign sy_en      = drv.direct_on;
    assign lvl_trk_en = drv.lvl_en;
    assign hi_trk_en  = drv.hi_en;
    assign lo_trk_en  = drv.lo_en;

    always_comb begin
        unique case (phase)
            PH_PARTIAL: ratio_code = DEEPEST;
            PH_FULL:    ratio_code = cnt;
            default:    ratio_code = '0;
        endcase
        if (phase == PH_FULL && cnt != '0) ref_sel = cnt - 1'b1;
        else                               ref_sel = cnt;
    end
endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             s1_en,
    input logic             s2_en,
    input logic             sx_en,
    input logic             sy_en,
    input logic [LVL_W-1:0] ratio_code,
    input logic [LVL_W-1:0] ref_sel,
    input logic             lvl_trk_en,
    input logic             hi_trk_en,
    input logic             lo_trk_en
);
    localparam logic [LVL_W-1:0] DEEPEST = '1;

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !((s1_en || s2_en) && (sx_en || sy_en)));

    assert_dead_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sx_en) |-> $past(!s1_en && !s2_en));

    assert_partial_ratio_R4: assert property (@(posedge clk) disable iff (rst)
        (s1_en && lo_trk_en) |-> (ratio_code == DEEPEST && !lvl_trk_en && !hi_trk_en));

    assert_ratio_gated_R3: assert property (@(posedge clk) disable iff (rst)
        !s1_en |-> (ratio_code == '0));

    assert_ref_below_R6: assert property (@(posedge clk) disable iff (rst)
        (s1_en && lvl_trk_en && ratio_code != '0) |-> (ref_sel == LVL_W'(ratio_code - 1'b1)));

    assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
        (s1_en && lvl_trk_en && $past(s1_en && lvl_trk_en)) |->
        (ratio_code == $past(ratio_code) || ratio_code == LVL_W'($past(ratio_code) - 1'b1)));

    assert_one_tracker_R1: assert property (@(posedge clk) disable iff (rst)
        !(lo_trk_en && (hi_trk_en || lvl_trk_en)));
endmodule

bind harvest_seq hs_checker #(.LVL_W(LVL_W)) u_hs_checker (
    .clk(clk), .rst(rst), .s1_en(s1_en), .s2_en(s2_en), .sx_en(sx_en),
    .sy_en(sy_en), .ratio_code(ratio_code), .ref_sel(ref_sel),
    .lvl_trk_en(lvl_trk_en), .hi_trk_en(hi_trk_en), .lo_trk_en(lo_trk_en)
);

// File: tb/tb_harvest_seq.sv
module tb_harvest_seq;
    localparam int STG = 2;
    localparam int SET = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [5:0] fl = '0;
    logic s1_en, s2_en, sx_en, sy_en, lvl_trk_en, hi_trk_en, lo_trk_en;
    logic [2:0] ratio_code, ref_sel;

    harvest_seq dut (
        .clk(clk), .rst(rst), .wake_i(fl[0]), .peak_i(fl[1]), .lvl_above_i(fl[2]),
        .hi_thr_i(fl[3]), .lo_thr_i(fl[4]), .rev_i(fl[5]),
        .s1_en(s1_en), .s2_en(s2_en), .sx_en(sx_en), .sy_en(sy_en),
        .ratio_code(ratio_code), .ref_sel(ref_sel),
        .lvl_trk_en(lvl_trk_en), .hi_trk_en(hi_trk_en), .lo_trk_en(lo_trk_en)
    );

    int total = 0, fails = 0, cyc = 0;

    // reference model state: 0 idle,1 track,2 partial,3 full,4 gap,5 direct,6 close
    int mph = 0, mcnt = 0, mhold = 0;
    logic [5:0] hist[$];
    logic [5:0] mhi, mlo;
    bit settle_req;

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; mcnt = 0; mhold = 0;
            hist = {6'd0, 6'd0, 6'd0, 6'd0};
        end else begin
            hist.push_front(fl);
            hist = hist[0:STG+1];
            mhi = hist[STG] & hist[STG+1];
            mlo = ~hist[STG] & ~hist[STG+1];
            settle_req = 0;
            case (mph)
                0: if (mhi[0]) begin mph = 1; settle_req = 1; end
                1: if (mhi[1]) begin mph = 3; settle_req = 1; end
                   else if (mhi[3]) begin mph = 2; mcnt = 7; end
                   else if (mhold == 0 && mhi[2]) begin
                       if (mcnt < 7) mcnt++;
                       settle_req = 1;
                   end
                2: if (mhi[4]) begin mph = 1; settle_req = 1; end
                3: if (mhold == 0 && mlo[2]) begin
                       if (mcnt <= 1) begin mph = 4; mcnt = 0; end
                       else begin mcnt--; settle_req = 1; end
                   end
                4: mph = 5;
                5: if (mhi[5]) mph = 6;
                default: begin mph = 0; mcnt = 0; end
            endcase
            if (settle_req) mhold = SET;
            else if (mhold > 0) mhold--;
        end
    end

    function automatic logic [12:0] expected();
        logic conv, dir;
        int r, f;
        conv = (mph == 2 || mph == 3);
        dir  = (mph == 5);
        r = (mph == 2) ? 7 : (mph == 3) ? mcnt : 0;
        f = (mph == 3 && mcnt > 0) ? mcnt - 1 : mcnt;
        return {conv, conv, dir, dir, (mph == 1 || mph == 3), (mph == 1), (mph == 2),
                3'(r), 3'(f)};
    endfunction

    function automatic string tag_of(int p);
        case (p)
            0: return "R1";  1: return "R3";  2: return "R4";  3: return "R7";
            4: return "R8";  5: return "R8";  default: return "R9";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural source
    int vin = 0, rise_left = 0, rise_per = 3, rc = 0, dc = 0;
    bit peaked = 0, wake_req = 0;
    // monitors
    int first_full, first_ref, last_full, pece_n, pece_ratio, rearm_ref;
    bit prev_s1, prev2_s1, prev_sx, prev_lo, saw_gap, gap_ok, any_hi;

    task automatic tick();
        logic [12:0] act, exp;
        @(negedge clk);
        act = {s1_en, s2_en, sx_en, sy_en, lvl_trk_en, hi_trk_en, lo_trk_en, ratio_code, ref_sel};
        exp = expected();
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s per-cycle outputs actual=%b expected=%b", tag_of(mph), act, exp);
        end
        if (s1_en && lvl_trk_en && first_full < 0) begin first_full = ratio_code; first_ref = ref_sel; end
        if (s1_en && lvl_trk_en) last_full = ratio_code;
        if (lo_trk_en && !prev_lo) begin pece_n++; if (pece_ratio < 0) pece_ratio = ratio_code; end
        if (hi_trk_en && prev_lo && rearm_ref < 0) rearm_ref = ref_sel;
        if (sx_en && !prev_sx) begin saw_gap = 1; gap_ok = (!prev_s1 && prev2_s1); end
        if (hi_trk_en) any_hi = 1;
        prev2_s1 = prev_s1; prev_s1 = s1_en; prev_sx = sx_en; prev_lo = lo_trk_en;
        if (s2_en || sx_en) begin
            dc++;
            if (dc >= 2) begin dc = 0; if (vin > 0) vin--; end
        end else if (rise_left > 0) begin
            rc++;
            if (rc >= rise_per) begin
                rc = 0; vin++; rise_left--;
                if (rise_left == 0) peaked = 1;
            end
        end
        fl[0] = wake_req;
        fl[1] = peaked;
        fl[2] = (vin > 10 + 5 * int'(ref_sel));
        fl[3] = (vin >= 45);
        fl[4] = (vin <= 44);
        fl[5] = sx_en && (vin <= 5);
    endtask

    task automatic clear_mon();
        first_full = -1; first_ref = -1; last_full = -1; pece_n = 0; pece_ratio = -1;
        rearm_ref = -1; saw_gap = 0; gap_ok = 0; any_hi = 0;
    endtask

    task automatic harvest(int rise, int rp);
        bit left;
        clear_mon();
        vin = 0; peaked = 0; rise_left = rise; rise_per = rp; rc = 0; dc = 0;
        wake_req = 1;
        repeat (3) tick();
        wake_req = 0;
        left = 0;
        for (int i = 0; i < 4000; i++) begin
            tick();
            if (mph != 0) left = 1;
            if (left && mph == 0) break;
        end
        repeat (3) tick();
        chk(!s1_en && !sx_en && !lvl_trk_en && !hi_trk_en && !lo_trk_en, "R9",
            "enables after harvest", int'({s1_en, sx_en, lvl_trk_en, hi_trk_en, lo_trk_en}), 0);
        chk(ref_sel == 0 && ratio_code == 0, "R9", "codes after harvest",
            int'({ratio_code, ref_sel}), 0);
        chk(saw_gap && gap_ok, "R8", "one dead cycle before direct path", int'(gap_ok), 1);
    endtask

    function automatic int steps_for(int v);
        int n = 0;
        for (int k = 0; k < 7; k++) if (v > 10 + 5 * k) n++;
        return n;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(!s1_en && !s2_en && !sx_en && !sy_en && !lvl_trk_en && !hi_trk_en && !lo_trk_en,
            "R1", "enables in reset", int'({s1_en, sx_en, lvl_trk_en}), 0);
        rst = 1'b0;
        tick();
        chk(ratio_code == 0 && ref_sel == 0, "R1", "codes after reset", int'({ratio_code, ref_sel}), 0);

        // R2: single-cycle wake glitch is ignored
        clear_mon();
        wake_req = 1; tick(); wake_req = 0;
        repeat (12) tick();
        chk(!any_hi, "R2", "one-cycle wake glitch left idle", int'(any_hi), 0);

        // R1: stray flags in idle are ignored
        clear_mon();
        vin = 50; peaked = 1;
        repeat (12) tick();
        chk(!any_hi && !s1_en, "R1", "idle ignores peak/high/level", int'({any_hi, s1_en}), 0);
        vin = 0; peaked = 0;
        repeat (6) tick();

        // weak excitation: peak at mid ladder
        harvest(28, 3);
        chk(first_full == steps_for(28), "R6", "first full-extraction ratio", first_full, steps_for(28));
        chk(first_ref == steps_for(28) - 1, "R6", "reference one step below", first_ref, steps_for(28) - 1);
        chk(last_full == 1, "R7", "ratio stepped down to lowest", last_full, 1);
        chk(pece_n == 0, "R4", "no partial burst below maximum", pece_n, 0);

        // strong excitation: repeated partial bursts
        harvest(60, 2);
        chk(pece_n >= 2, "R5", "partial bursts repeat before peak", pece_n, 2);
        chk(pece_ratio == 7, "R4", "partial burst ratio code", pece_ratio, 7);
        chk(rearm_ref == 7, "R3", "count saturated at 7 after burst", rearm_ref, 7);
        chk(first_full == 7, "R6", "full extraction starts at 1/8", first_full, 7);
        chk(first_ref == 6, "R6", "full extraction reference", first_ref, 6);

        // very weak excitation: peak before the first level
        harvest(6, 3);
        chk(first_full == 0 && first_ref == 0, "R6", "full extraction at count 0",
            first_full * 8 + first_ref, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; fails++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule